// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps wall-clock time and calendar date as seven packed-BCD registers (seconds, minutes, hours, day of week, day of month, month, two-digit year). Every cycle in which the single-cycle `tick` enable is high, the time advances by one second. Each register carries into the next. The day of month wraps according to the length of the current month, and February follows a leap-year rule. The day-of-week counter runs on its own, independent of the date. A century bit sits in the hours register and flips when the year wraps, but only if its enable bit is set.

A parallel write port loads any single register. Address 7 reaches a sticky oscillator-stop flag. All registers are presented continuously on output ports, so a read buffer can capture a coherent snapshot. A halt bit in the seconds register stops counting, as does an external oscillator-loss indication. Any change from running to stopped raises the stop flag, and reset raises it too. Reset is synchronous and active high. Tick generation and any serial access lie outside the block.

Top module: `rtc_calendar_core`

## Requirements
- R1: Seconds and minutes count 00 to 59 in packed BCD. A low digit of 9 carries into the high digit. Seconds at 59 wrap to 00 and advance minutes; minutes at 59 wrap to 00 and advance hours.
- R2: Hours count 00 to 23 in bits 5:0 of the hours register. At 23, a carry wraps hours to 00 and produces a day roll.
- R3: On a day roll, the date advances unless it equals the current month's last day (31; 30 for months 04, 06, 09 and 11; 28 or 29 for 02). At the last day it returns to 01 and the month advances.
- R4: A year whose BCD value is divisible by 4 (including 00) is a leap year, in which February has 29 days; in other years it has 28.
- R5: The day of week (bits 2:0) advances on each day roll and wraps from 7 to 1, whatever the date does.
- R6: Month 12 wraps to 01 and advances the year, and year 99 wraps to 00. At that year wrap, hours bit 6 (century) toggles if hours bit 7 (century enable) is 1, and holds otherwise.
- R7: After reset the registers read seconds 00, minutes 00, hours 00, day 01, date 01, month 01, year 00. The halt bit and both century bits are 0, and the stop flag is 1.
- R8: While seconds bit 7 (halt) is 1, ticks have no effect and every register holds its value. Clearing the bit resumes counting.
- R9: The stop flag is set in the cycle after the oscillator goes from running to stopped, where stopped means halt is 1 or `osc_lost` is high. A write to address 7 with bit 7 at 0 clears the flag. A write with bit 7 at 1 leaves it unchanged.
- R10: When a write and a tick fall in the same cycle, the write is applied and that tick is discarded.
- R11: The write addresses are 0 seconds, 1 minutes, 2 hours, 3 day, 4 date, 5 month, 6 year and 7 flag. Bits with no storage read 0: minutes bit 7, day bits 7:3, date bits 7:6 and month bits 7:5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| tick | input | 1 | One-cycle 1 Hz advance enable |
| osc_lost | input | 1 | Oscillator not running (external indication) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select for a write |
| wr_data | input | 8 | Write data |
| sec_o | output | 8 | Halt bit and BCD seconds |
| min_o | output | 8 | BCD minutes |
| hour_o | output | 8 | Century enable, century and BCD hours |
| dow_o | output | 8 | Day of week 1 to 7 |
| date_o | output | 8 | BCD day of month |
| month_o | output | 8 | BCD month |
| year_o | output | 8 | BCD year |
| stop_flag_o | output | 1 | Oscillator-stop flag |

## Verification
Register writes and tick-driven advance can land in the same cycle. The bench forces this by asserting `tick` together with a write to minutes and then to seconds. It expects the written byte to appear unchanged and the untouched seconds not to move. A second collision comes from pulsing `osc_lost` in a tick cycle, which must raise the stop flag and suppress counting. Every outcome is judged at the ports one cycle after the event, against values the bench derives from the requirements.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int BYTE_W  = 8;
  localparam int N_FIELD = 7;

  typedef enum logic [2:0] {
    A_SEC  = 3'd0,
    A_MIN  = 3'd1,
    A_HOUR = 3'd2,
    A_DOW  = 3'd3,
    A_DATE = 3'd4,
    A_MON  = 3'd5,
    A_YEAR = 3'd6,
    A_FLAG = 3'd7
  } cal_addr_e;

  // Next packed-BCD value; a low digit of 9 or more carries.
  function automatic logic [BYTE_W-1:0] bcd_inc(input logic [BYTE_W-1:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // 10*T + O is divisible by 4 exactly when 2*T + O is.
  function automatic logic bcd_leap(input logic [BYTE_W-1:0] y);
    logic [4:0] s;
    s = {1'b0, y[3:0]} + (y[4] ? 5'd2 : 5'd0);
    return (s[1:0] == 2'b00);
  endfunction

  function automatic logic [BYTE_W-1:0] bcd_month_len(input logic [BYTE_W-1:0] m,
                                                      input logic [BYTE_W-1:0] y);
    case (m)
      8'h02:                      return bcd_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
  parameter int          FW = 7,
  parameter logic [7:0]  LO = 8'h00
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [FW-1:0] load_val,
  input  logic          step,
  input  logic [7:0]    limit,
  output logic [FW-1:0] val,
  output logic          at_limit
);
  logic [7:0] ext;

  assign ext      = 8'(val);
  assign at_limit = (ext == limit);

  always_ff @(posedge clk) begin
    if (rst)       val <= LO[FW-1:0];
    else if (load) val <= load_val;
    else if (step) val <= at_limit ? LO[FW-1:0] : FW'(rtc_cal_pkg::bcd_inc(ext));
  end
endmodule

// File: rtl/rtc_century.sv
module rtc_century (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [1:0] load_val,
  input  logic       roll,
  output logic       en_o,
  output logic       cent_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_o   <= 1'b0;
      cent_o <= 1'b0;
    end else if (load) begin
      en_o   <= load_val[1];
      cent_o <= load_val[0];
    end else if (roll && en_o) begin
      cent_o <= ~cent_o;
    end
  end
endmodule

// File: rtl/rtc_stop_flag.sv
module rtc_stop_flag (
  input  logic clk,
  input  logic rst,
  input  logic running,
  input  logic clr_wr,
  input  logic clr_bit,
  output logic flag_o
);
  logic run_q;
  logic stop_evt;

  assign stop_evt = run_q & ~running;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      flag_o <= 1'b1;
    end else begin
      run_q <= running;
      if (stop_evt)                flag_o <= 1'b1;
      else if (clr_wr && !clr_bit) flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       osc_lost,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o,
  output logic       stop_flag_o
);
  import rtc_cal_pkg::*;

  localparam int         FW_T [N_FIELD] = '{7, 7, 6, 3, 6, 5, 8};
  localparam logic [7:0] LO_T [N_FIELD] = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};

  logic [N_FIELD-1:0][7:0] vals;
  logic [N_FIELD-1:0][7:0] limits;
  logic [N_FIELD-1:0]      steps;
  logic [N_FIELD-1:0]      atl;
  logic [N_FIELD-1:0]      loads;

  logic halt_q, running, adv;
  logic min_step, hr_step, day_roll, week_roll, mon_step, year_step, year_roll;
  logic cen_en, cent;

  // Named events used by the counters and by the checker.
  assign running   = ~halt_q & ~osc_lost;
  assign adv       = tick & ~wr_en & running;
  assign min_step  = adv & atl[0];
  assign hr_step   = min_step & atl[1];
  assign day_roll  = hr_step & atl[2];
  assign week_roll = day_roll & atl[3];
  assign mon_step  = day_roll & atl[4];
  assign year_step = mon_step & atl[5];
  assign year_roll = year_step & atl[6];

  assign steps = {year_step, mon_step, day_roll, day_roll, hr_step, min_step, adv};

  always_comb begin
    limits[0] = 8'h59;
    limits[1] = 8'h59;
    limits[2] = 8'h23;
    limits[3] = 8'h07;
    limits[4] = bcd_month_len(vals[5], vals[6]);
    limits[5] = 8'h12;
    limits[6] = 8'h99;
  end

  for (genvar i = 0; i < N_FIELD; i++) begin : g_fld
    localparam int FW = FW_T[i];
    logic [FW-1:0] v;

    assign loads[i] = wr_en && (wr_addr == 3'(i));

    rtc_bcd_field #(.FW(FW), .LO(LO_T[i])) u_fld (
      .clk      (clk),
      .rst      (rst),
      .load     (loads[i]),
      .load_val (wr_data[FW-1:0]),
      .step     (steps[i]),
      .limit    (limits[i]),
      .val      (v),
      .at_limit (atl[i])
    );

    assign vals[i] = 8'(v);
  end

  always_ff @(posedge clk) begin
    if (rst)           halt_q <= 1'b0;
    else if (loads[0]) halt_q <= wr_data[7];
  end

  rtc_century u_cent (
    .clk      (clk),
    .rst      (rst),
    .load     (loads[2]),
    .load_val (wr_data[7:6]),
    .roll     (year_roll),
    .en_o     (cen_en),
    .cent_o   (cent)
  );

  rtc_stop_flag u_flag (
    .clk     (clk),
    .rst     (rst),
    .running (running),
    .clr_wr  (wr_en && (wr_addr == A_FLAG)),
    .clr_bit (wr_data[7]),
    .flag_o  (stop_flag_o)
  );

  assign sec_o   = {halt_q, vals[0][6:0]};
  assign min_o   = vals[1];
  assign hour_o  = {cen_en, cent, vals[2][5:0]};
  assign dow_o   = vals[3];
  assign date_o  = vals[4];
  assign month_o = vals[5];
  assign year_o  = vals[6];
endmodule

// File: rtl/rtc_calendar_core_chk.sv
module rtc_calendar_core_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       adv,
  input logic       day_roll,
  input logic       week_roll,
  input logic       year_roll,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [7:0] dow_o,
  input logic [7:0] date_o,
  input logic [7:0] month_o,
  input logic [7:0] year_o,
  input logic       stop_flag_o
);
  a_r1_sec_wrap: assert property (@(posedge clk) disable iff (rst)
    adv && sec_o[6:0] == 7'h59 |=> sec_o[6:0] == 7'h00);

  a_r3_date_last: assert property (@(posedge clk) disable iff (rst)
    day_roll && date_o == 8'h31 |=> date_o == 8'h01);

  a_r5_dow_wrap: assert property (@(posedge clk) disable iff (rst)
    week_roll |=> dow_o == 8'h01);

  a_r6_century_flip: assert property (@(posedge clk) disable iff (rst)
    year_roll && hour_o[7] |=> hour_o[6] != $past(hour_o[6]));

  a_r6_century_hold: assert property (@(posedge clk) disable iff (rst)
    year_roll && !hour_o[7] |=> $stable(hour_o[6]));

  a_r8_halt_hold: assert property (@(posedge clk) disable iff (rst)
    sec_o[7] && !wr_en |=> $stable({sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o}));

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    stop_flag_o && !(wr_en && wr_addr == 3'd7 && !wr_data[7]) |=> stop_flag_o);

  a_r10_write_wins: assert property (@(posedge clk) disable iff (rst)
    wr_en && tick && wr_addr == 3'd0 |=> sec_o == $past(wr_data));
endmodule

bind rtc_calendar_core rtc_calendar_core_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .tick        (tick),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .adv         (adv),
  .day_roll    (day_roll),
  .week_roll   (week_roll),
  .year_roll   (year_roll),
  .sec_o       (sec_o),
  .min_o       (min_o),
  .hour_o      (hour_o),
  .dow_o       (dow_o),
  .date_o      (date_o),
  .month_o     (month_o),
  .year_o      (year_o),
  .stop_flag_o (stop_flag_o)
);

// File: tb/rtc_calendar_core_tb.sv
module rtc_calendar_core_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, osc_lost = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;
  logic       stop_flag_o;

  typedef struct {
    string      req;
    logic [7:0] sec, mn, hr, dow, date, mon, yr;
    logic       flg;
  } exp_t;

  exp_t cur;
  exp_t sb_q[$];
  int   n_chk = 0, n_fail = 0;
  bit   done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_calendar_core u_dut (
    .clk(clk), .rst(rst), .tick(tick), .osc_lost(osc_lost),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
    .date_o(date_o), .month_o(month_o), .year_o(year_o),
    .stop_flag_o(stop_flag_o)
  );

  task automatic cmp(input string req, input string nm, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, nm, act, exp);
    end
  endtask

  // Monitor: pops expected snapshots and compares them with the ports.
  initial begin
    forever begin
      wait (sb_q.size() > 0);
      #1;
      begin
        exp_t e;
        e = sb_q.pop_front();
        cmp(e.req, "sec",   sec_o,   e.sec);
        cmp(e.req, "min",   min_o,   e.mn);
        cmp(e.req, "hour",  hour_o,  e.hr);
        cmp(e.req, "dow",   dow_o,   e.dow);
        cmp(e.req, "date",  date_o,  e.date);
        cmp(e.req, "month", month_o, e.mon);
        cmp(e.req, "year",  year_o,  e.yr);
        cmp(e.req, "flag",  8'(stop_flag_o), 8'(e.flg));
      end
    end
  end

  // Driver side: one idle cycle, then push the expected snapshot.
  task automatic expect_now(input string req);
    @(negedge clk);
    cur.req = req;
    sb_q.push_back(cur);
    wait (sb_q.size() == 0);
    #2;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic tk = 1'b0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; tick = tk;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic load(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                      input logic [7:0] w, input logic [7:0] d, input logic [7:0] mo,
                      input logic [7:0] y);
    wr(3'd0, s); wr(3'd1, m); wr(3'd2, h); wr(3'd3, w);
    wr(3'd4, d); wr(3'd5, mo); wr(3'd6, y);
    cur.sec = s; cur.mn = m; cur.hr = h; cur.dow = w; cur.date = d; cur.mon = mo; cur.yr = y;
  endtask

  task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h);
    wr(3'd0, s); wr(3'd1, m); wr(3'd2, h);
    cur.sec = s; cur.mn = m; cur.hr = h;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R7 reset state
    cur = '{req: "R7", sec: 8'h00, mn: 8'h00, hr: 8'h00, dow: 8'h01, date: 8'h01,
            mon: 8'h01, yr: 8'h00, flg: 1'b1};
    expect_now("R7");

    // R9 writing 1 leaves the flag, writing 0 clears it
    wr(3'd7, 8'h80);
    expect_now("R9");
    wr(3'd7, 8'h00); cur.flg = 1'b0;
    expect_now("R9");

    // R1 plain second step, then R2/R3/R5 full-day rollover into March
    load(8'h58, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h23);
    do_tick(); cur.sec = 8'h59;
    expect_now("R1");
    do_tick();
    cur.sec = 8'h00; cur.mn = 8'h00; cur.hr = 8'h00; cur.dow = 8'h01; cur.date = 8'h01; cur.mon = 8'h03;
    expect_now("R2_R3_R5");

    // R4 year 24 is leap
    load(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24);
    do_tick();
    cur.sec = 8'h00; cur.mn = 8'h00; cur.hr = 8'h00; cur.dow = 8'h04; cur.date = 8'h29;
    expect_now("R4");
    set_time(8'h59, 8'h59, 8'h23);
    do_tick();
    cur.sec = 8'h00; cur.mn = 8'h00; cur.hr = 8'h00; cur.dow = 8'h05; cur.date = 8'h01; cur.mon = 8'h03;
    expect_now("R3");

    // R4 year 12 leap (odd tens digit), year 10 not leap
    load(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h12);
    do_tick();
    cur.sec = 8'h00; cur.mn = 8'h00; cur.hr = 8'h00; cur.dow = 8'h02; cur.date = 8'h29;
    expect_now("R4");
    load(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h10);
    do_tick();
    cur.sec = 8'h00; cur.mn = 8'h00; cur.hr = 8'h00; cur.dow = 8'h02; cur.date = 8'h01; cur.mon = 8'h03;
    expect_now("R4");

    // R3 thirty-day month
    load(8'h59, 8'h59, 8'h23, 8'h06, 8'h30, 8'h04, 8'h05);
    do_tick();
    cur.sec = 8'h00; cur.mn = 8'h00; cur.hr = 8'h00; cur.dow = 8'h07; cur.date = 8'h01; cur.mon = 8'h05;
    expect_now("R3");

    // R6 year wrap with century enabled: century toggles
    load(8'h59, 8'h59, 8'hA3, 8'h07, 8'h31, 8'h12, 8'h99);
    do_tick();
    cur.sec = 8'h00; cur.mn = 8'h00; cur.hr = 8'hC0; cur.dow = 8'h01; cur.date = 8'h01;
    cur.mon = 8'h01; cur.yr = 8'h00;
    expect_now("R6");
    // R6 century enable off: century holds
    load(8'h59, 8'h59, 8'h63, 8'h02, 8'h31, 8'h12, 8'h99);
    do_tick();
    cur.sec = 8'h00; cur.mn = 8'h00; cur.hr = 8'h40; cur.dow = 8'h03; cur.date = 8'h01;
    cur.mon = 8'h01; cur.yr = 8'h00;
    expect_now("R6");

    // R1 digit carry into minutes tens
    load(8'h59, 8'h09, 8'h10, 8'h01, 8'h15, 8'h06, 8'h30);
    do_tick();
    cur.sec = 8'h00; cur.mn = 8'h10;
    expect_now("R1");

    // R8 halt freezes counting; R9 halting raises the flag
    wr(3'd0, 8'h90); cur.sec = 8'h90; cur.flg = 1'b1;
    expect_now("R8_R9");
    do_tick(); do_tick();
    expect_now("R8");
    wr(3'd7, 8'h00); cur.flg = 1'b0;
    expect_now("R9");
    wr(3'd0, 8'h10); cur.sec = 8'h10;
    expect_now("R8");
    do_tick(); cur.sec = 8'h11;
    expect_now("R8");

    // R9 oscillator loss with a tick in the same cycle
    @(negedge clk);
    osc_lost = 1'b1; tick = 1'b1;
    @(negedge clk);
    osc_lost = 1'b0; tick = 1'b0;
    cur.flg = 1'b1;
    expect_now("R9");
    wr(3'd7, 8'h00); cur.flg = 1'b0;
    expect_now("R9");

    // R10 write and tick in one cycle: write wins, tick dropped
    wr(3'd1, 8'h42, 1'b1); cur.mn = 8'h42;
    expect_now("R10");
    wr(3'd0, 8'h33, 1'b1); cur.sec = 8'h33;
    expect_now("R10");

    // R11 address map and bits without storage
    wr(3'd3, 8'hF3); cur.dow  = 8'h03;
    wr(3'd5, 8'hF2); cur.mon  = 8'h12;
    wr(3'd1, 8'hA5); cur.mn   = 8'h25;
    wr(3'd4, 8'hC7); cur.date = 8'h07;
    expect_now("R11");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule